// File: doc/BRIEF.md
# DMA Engine Status Flag Register

This block holds the status word of a descriptor-chained DMA engine. The engine core reports its chain events as one-cycle strobes: a descriptor has been fetched, a descriptor has finished (with a flag that marks the last descriptor of a chain), an internal bus error has occurred, or a master abort has occurred. The block turns these strobes into flag bits in one 32-bit register.

Software reads the register through a simple 32-bit register port. One bit is a busy indication owned by hardware. Three bits are event flags that clear when the register is read. Writes have no effect on the register. A level interrupt stays asserted while any event flag is pending, so a handler reads the word once to learn the cause and to acknowledge it.

Top module: `dma_status_reg`

## Requirements
- R1: Read data bits 31:11, 7:6 and 4:0 are always 0. Reads at any address other than the register offset (default 0x1804) return all zeros.
- R2: After reset all flags are 0 and `irq` is low.
- R3: The busy flag at bit 10 is 1 from the cycle after a `ev_desc_fetch` strobe.
- R4: The busy flag clears in the cycle after `ev_bus_err`. It also clears in the cycle after `ev_desc_done` with `ev_desc_last` = 1 while `desc_wb_en` = 0. With `desc_wb_en` = 1 the busy flag is kept. If a clearing event and a fetch occur in the same cycle, the clearing event wins.
- R5: The transfer-done flag at bit 9 sets after `ev_desc_done` with `ev_desc_last` = 0.
- R6: The chain-done flag at bit 8 sets after `ev_desc_done` with `ev_desc_last` = 1.
- R7: The abort flag at bit 5 sets after `ev_master_abort`.
- R8: A read at the register offset returns the current flags in the same cycle. It clears bits 9, 8 and 5 at the following clock edge and leaves bit 10 unchanged.
- R9: If a set event for a read-clear flag and a clearing read occur in the same cycle, the flag ends up set.
- R10: `irq` is high exactly while bit 9, 8 or 5 is set. It falls in the cycle after a read that clears the last pending flag.
- R11: Writes, including writes at the register offset with all data bits set, change no bit. A read at another address clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access valid |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Local byte offset of the access |
| reg_wdata | input | 32 | Write data, which the register ignores |
| reg_rdata | output | 32 | Read data, combinational in the access cycle |
| ev_desc_fetch | input | 1 | Strobe: chain descriptor read from memory |
| ev_desc_done | input | 1 | Strobe: descriptor processed, interrupt signalled |
| ev_desc_last | input | 1 | Qualifies `ev_desc_done`: next-descriptor address was NULL |
| ev_bus_err | input | 1 | Strobe: internal bus error |
| ev_master_abort | input | 1 | Strobe: master abort while the engine was bus master |
| desc_wb_en | input | 1 | Descriptor write-enable control bit |
| irq | output | 1 | Level interrupt |

## Verification
The vector walk first sends non-last and last completions separately, so that bits 9 and 8 can be told apart. It then sends a last completion with the write-enable bit at each value, which shows whether the busy flag depends on that control. Error and fetch strobes arrive in the same cycle to expose the priority of the busy flag. A master abort coincides with a clearing read to show that the set wins. Writes with all ones, reads at a neighbouring offset and a mid-run reset show that bits change only on their own events.

// File: rtl/dma_status_reg.sv
module dma_status_reg #(
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 32,
  parameter logic [ADDR_W-1:0] REG_OFF = 16'h1804
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_desc_fetch,
  input  logic              ev_desc_done,
  input  logic              ev_desc_last,
  input  logic              ev_bus_err,
  input  logic              ev_master_abort,
  input  logic              desc_wb_en,
  output logic              irq
);
  localparam int BIT_BUSY  = 10;
  localparam int BIT_XFER  = 9;
  localparam int BIT_CHAIN = 8;
  localparam int BIT_ABORT = 5;

  logic busy_q, xfer_q, chain_q, abort_q;
  logic rd_hit, wr_hit, busy_clr;
  logic set_xfer, set_chain;

  assign rd_hit    = reg_en && !reg_wr && (reg_addr == REG_OFF);
  assign wr_hit    = reg_en &&  reg_wr && (reg_addr == REG_OFF);
  assign set_xfer  = ev_desc_done && !ev_desc_last;
  assign set_chain = ev_desc_done &&  ev_desc_last;
  assign busy_clr  = ev_bus_err || (set_chain && !desc_wb_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      xfer_q  <= 1'b0;
      chain_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (busy_clr)           busy_q <= 1'b0;
      else if (ev_desc_fetch) busy_q <= 1'b1;
      xfer_q  <= set_xfer        || (xfer_q  && !rd_hit);
      chain_q <= set_chain       || (chain_q && !rd_hit);
      abort_q <= ev_master_abort || (abort_q && !rd_hit);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (rd_hit) begin
      reg_rdata[BIT_BUSY]  = busy_q;
      reg_rdata[BIT_XFER]  = xfer_q;
      reg_rdata[BIT_CHAIN] = chain_q;
      reg_rdata[BIT_ABORT] = abort_q;
    end
  end

  assign irq = xfer_q || chain_q || abort_q;

  logic unused_ok;
  assign unused_ok = ^{reg_wdata, wr_hit};
endmodule

// File: rtl/dma_status_reg_chk.sv
module dma_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_hit,
  input logic        wr_hit,
  input logic [31:0] reg_rdata,
  input logic        ev_desc_fetch,
  input logic        ev_desc_done,
  input logic        ev_desc_last,
  input logic        ev_bus_err,
  input logic        ev_master_abort,
  input logic        desc_wb_en,
  input logic        busy_q,
  input logic        xfer_q,
  input logic        chain_q,
  input logic        abort_q,
  input logic        irq
);
  logic quiet;
  assign quiet = !ev_desc_fetch && !ev_desc_done && !ev_bus_err && !ev_master_abort;

  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 32'hFFFF_F8DF) == 32'h0);

  p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_fetch && !ev_bus_err && !(ev_desc_done && ev_desc_last && !desc_wb_en) |=> busy_q);

  p_busy_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> !busy_q);

  p_busy_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_done && ev_desc_last && !desc_wb_en |=> !busy_q);

  p_xfer_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_done && !ev_desc_last |=> xfer_q);

  p_chain_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_done && ev_desc_last |=> chain_q);

  p_abort_set_r7_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_master_abort |=> abort_q);

  p_rc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && quiet |=> !xfer_q && !chain_q && !abort_q && busy_q == $past(busy_q));

  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_hit));

  p_wr_noeffect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && quiet |=> $stable({busy_q, xfer_q, chain_q, abort_q}));
endmodule

bind dma_status_reg dma_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .wr_hit(wr_hit), .reg_rdata(reg_rdata),
  .ev_desc_fetch(ev_desc_fetch), .ev_desc_done(ev_desc_done), .ev_desc_last(ev_desc_last),
  .ev_bus_err(ev_bus_err), .ev_master_abort(ev_master_abort), .desc_wb_en(desc_wb_en),
  .busy_q(busy_q), .xfer_q(xfer_q), .chain_q(chain_q), .abort_q(abort_q), .irq(irq)
);

// File: tb/dma_status_reg_tb.sv
module dma_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_desc_fetch = 1'b0, ev_desc_done = 1'b0, ev_desc_last = 1'b0;
  logic        ev_bus_err = 1'b0, ev_master_abort = 1'b0, desc_wb_en = 1'b0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  localparam logic [15:0] OFF = 16'h1804;

  always #2 clk = ~clk;

  dma_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_desc_fetch(ev_desc_fetch),
    .ev_desc_done(ev_desc_done), .ev_desc_last(ev_desc_last), .ev_bus_err(ev_bus_err),
    .ev_master_abort(ev_master_abort), .desc_wb_en(desc_wb_en), .irq(irq)
  );

  // {F,D,L,E,M,W,R,X} controls, expected read data [10:0], expected irq
  localparam int NV = 18;
  localparam logic [19:0] VEC [NV] = '{
    {8'b00000010, 11'h000, 1'b0},  // R2 reset state
    {8'b10000000, 11'h000, 1'b0},  // R3 fetch
    {8'b00000010, 11'h400, 1'b0},  // R3 busy visible
    {8'b01000000, 11'h000, 1'b0},  // R5 non-last done
    {8'b00000010, 11'h600, 1'b1},  // R5 R8 read clears
    {8'b00000000, 11'h000, 1'b0},  // R10 irq fell
    {8'b01100100, 11'h000, 1'b0},  // R4 last done, wb_en=1
    {8'b00000010, 11'h500, 1'b1},  // R6 R4 busy kept
    {8'b01100000, 11'h000, 1'b0},  // R4 last done, wb_en=0
    {8'b00000010, 11'h100, 1'b1},  // R6 R4 busy cleared
    {8'b10001000, 11'h000, 1'b0},  // R7 abort + fetch
    {8'b00000001, 11'h000, 1'b1},  // R11 write all ones
    {8'b00000010, 11'h420, 1'b1},  // R7 R11 R1 unchanged
    {8'b00010000, 11'h000, 1'b0},  // R4 bus error
    {8'b00001010, 11'h000, 1'b0},  // R9 abort with read
    {8'b00000010, 11'h020, 1'b1},  // R9 set won
    {8'b10010000, 11'h000, 1'b0},  // R4 error beats fetch
    {8'b00000010, 11'h000, 1'b0}   // R4 busy stays 0
  };

  function automatic string tag(input int i);
    case (i)
      0: return "R2";  1, 2: return "R3";  3, 4: return "R5";  5: return "R10";
      6, 7, 8, 9: return "R4";  10: return "R7";  11, 12: return "R11";
      13, 16, 17: return "R4";  default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] c, input logic [15:0] a);
    {ev_desc_fetch, ev_desc_done, ev_desc_last, ev_bus_err, ev_master_abort, desc_wb_en} = c[7:2];
    reg_en    = c[1] | c[0];
    reg_wr    = c[0];
    reg_addr  = a;
    reg_wdata = c[0] ? 32'hFFFF_FFFF : 32'h0;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][19:12], OFF);
      #1;
      check(tag(i), reg_rdata, {21'b0, VEC[i][11:1]});
      check(tag(i), {31'b0, irq}, {31'b0, VEC[i][0]});
    end
    // R1 R11: read at another offset returns 0 and clears nothing
    @(negedge clk); drive(8'b01000000, OFF);
    @(negedge clk); drive(8'b00000010, OFF + 16'd4); #1;
    check("R1", reg_rdata, 32'h0);
    @(negedge clk); drive(8'b00000010, OFF); #1;
    check("R11", reg_rdata, 32'h200);
    // R1: read data width with write at neighbouring offset
    @(negedge clk); drive(8'b00000001, OFF - 16'd4);
    @(negedge clk); drive(8'b00000000, OFF); #1;
    check("R10", {31'b0, irq}, 32'h0);
    // R2: reset mid-run clears everything
    @(negedge clk); drive(8'b10001000, OFF);
    @(negedge clk); drive(8'b00000000, OFF); #1;
    check("R7", {31'b0, irq}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; drive(8'b00000010, OFF); #1;
    check("R2", reg_rdata, 32'h0);
    check("R2", {31'b0, irq}, 32'h0);
    @(negedge clk); drive(8'b00000000, OFF);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule